// File: doc/BRIEF.md
# OTG ID Pin Debounce and Role Filter

This block sits in the PHY clock domain of a dual-role USB controller. It takes the unfiltered level of the ID pin, brings it into the local clock domain through a two-flop synchronizer, and decides whether the controller should act as host or as device. A role change is reported only after the requested role has held steady for a long, fixed number of PHY clock cycles. The default is 300,000 cycles, which is about 10 ms at 30 MHz and about 50 ms at 6 MHz.

Software can override the pin with a force-host or force-device request. Force-host has priority. Applying or releasing either request restarts the same settle timer. The role therefore never changes sooner than the full settle time after the last force edge. Software can poll the busy flag, or wait for the one-cycle change pulse, to learn when the switch is done. A static enable input bypasses the timer when the PHY already debounces the pin.

Top module: `otg_role_filter`

## Requirements
- R1: During and right after synchronous reset, role_host is 0 (device), role_chg is 0 and busy is 0, whatever the level on id_raw. Encoding: id_raw 1 means device level and 0 means host level. role_host 1 means host.
- R2: With filter_en=1 and no force, suppose id_raw changes just before clock edge k and then holds. role_host then takes the new role at edge k+1+SETTLE_CYCLES and not before.
- R3: If id_raw returns to the level of the current role before the settle time has elapsed, the role does not change. busy falls two edges after the return.
- R4: The requested role is host when force_host=1, whatever force_dev is. Otherwise it is device when force_dev=1. With neither asserted, the synchronized pin decides.
- R5: With filter_en=1, suppose a force input changes just before edge f and the requested role then differs from the current role. role_host switches at edge f+SETTLE_CYCLES.
- R6: A force change restarts the count even when the requested role is unchanged. A count already in progress starts over from zero.
- R7: With filter_en=1, busy is 1 exactly while the requested role differs from role_host. With filter_en=0, busy is 0.
- R8: role_chg is a one-cycle pulse in the cycle role_host takes a new value, and is 0 at all other times.
- R9: With filter_en=0, a change of id_raw just before edge k appears on role_host at edge k+2, with no settle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst | input | 1 | Synchronous active-high reset |
| filter_en | input | 1 | Static: 1 selects the settle timer, 0 bypasses it |
| id_raw | input | 1 | Asynchronous ID pin level, 1 = device, 0 = host |
| force_host | input | 1 | Software request to act as host |
| force_dev | input | 1 | Software request to act as device |
| role_host | output | 1 | Reported role, 1 = host, 0 = device |
| role_chg | output | 1 | One-cycle pulse when role_host changes |
| busy | output | 1 | Settle count in progress |

## Verification
The assertions assume that filter_en is static and only changes while rst is asserted. They also assume that reset is held for at least two cycles, so the synchronizer and the force-edge register start from known values. The stimulus respects both assumptions: it changes filter_en only inside a reset pulse and holds reset for several cycles. It changes id_raw and the force inputs on the falling clock edge, so every expected cycle can be counted from a known rising edge. The settle count is shortened to 16 cycles, which lets glitches, restarts and full settles all fit in a short run.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;

  // ID pin level that means "device"; the synchronizer resets to it.
  localparam logic ID_DEVICE_LEVEL = 1'b1;

  // Requested role: force_host beats force_dev, which beats the pin.
  function automatic logic pick_host(input logic id_level,
                                     input logic f_host,
                                     input logic f_dev);
    if (f_host)      return 1'b1;
    else if (f_dev)  return 1'b0;
    else             return (id_level != ID_DEVICE_LEVEL);
  endfunction

endpackage

// File: rtl/id_sync.sv
module id_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  import otg_role_pkg::*;

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= ID_DEVICE_LEVEL;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= ID_DEVICE_LEVEL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/role_select.sv
module role_select (
  input  logic clk,
  input  logic rst,
  input  logic id_level,
  input  logic force_host,
  input  logic force_dev,
  output logic cand_host,
  output logic restart
);
  import otg_role_pkg::*;

  logic [1:0] force_prev;

  always_ff @(posedge clk) begin
    if (rst) force_prev <= 2'b00;
    else     force_prev <= {force_host, force_dev};
  end

  always_comb begin
    cand_host = pick_host(id_level, force_host, force_dev);
    restart   = ({force_host, force_dev} != force_prev);
  end

  // R4: with force_host held, the requested role is host
  a_r4_host_wins: assert property (@(posedge clk) disable iff (rst)
    force_host |-> cand_host);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYCLES = 300000
) (
  input  logic clk,
  input  logic rst,
  input  logic filter_en,
  input  logic cand_host,
  input  logic restart,
  output logic role_host,
  output logic role_chg,
  output logic busy
);
  localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          role_q;
  logic          chg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      role_q <= 1'b0;
      chg_q  <= 1'b0;
    end else if (!filter_en) begin
      cnt    <= '0;
      role_q <= cand_host;
      chg_q  <= (cand_host != role_q);
    end else if (cand_host == role_q || restart) begin
      cnt    <= '0;
      chg_q  <= 1'b0;
    end else if (cnt == LAST) begin
      cnt    <= '0;
      role_q <= cand_host;
      chg_q  <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      chg_q  <= 1'b0;
    end
  end

  assign role_host = role_q;
  assign role_chg  = chg_q;
  assign busy      = filter_en && (cand_host != role_q);

  // R2: the counter stays inside the settle window
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R8: the pulse marks exactly the cycles where the role moved
  a_r8_chg_on_move: assert property (@(posedge clk) disable iff (rst)
    role_chg |-> (role_host != $past(role_host)));
  a_r8_move_has_chg: assert property (@(posedge clk) disable iff (rst)
    (role_host != $past(role_host)) |-> role_chg);

  // R7: in filtered mode, no change without a pending count
  a_r7_idle_no_change: assert property (@(posedge clk) disable iff (rst)
    (filter_en && !busy) |=> !role_chg);

  // R9: bypass mode never reports busy
  a_r9_bypass_not_busy: assert property (@(posedge clk) disable iff (rst)
    !filter_en |-> !busy);
endmodule

// File: rtl/otg_role_filter.sv
module otg_role_filter #(
  parameter int SETTLE_CYCLES = 300000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic filter_en,
  input  logic id_raw,
  input  logic force_host,
  input  logic force_dev,
  output logic role_host,
  output logic role_chg,
  output logic busy
);
  logic id_s;
  logic cand_host;
  logic restart;

  id_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (id_raw),
    .q_sync  (id_s)
  );

  role_select u_sel (
    .clk        (clk),
    .rst        (rst),
    .id_level   (id_s),
    .force_host (force_host),
    .force_dev  (force_dev),
    .cand_host  (cand_host),
    .restart    (restart)
  );

  settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .filter_en (filter_en),
    .cand_host (cand_host),
    .restart   (restart),
    .role_host (role_host),
    .role_chg  (role_chg),
    .busy      (busy)
  );

  // R1: the first cycle out of reset reports device
  a_r1_device_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!role_host && !role_chg));
endmodule

// File: tb/otg_role_filter_bench.sv
module otg_role_filter_bench;
  localparam int S = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic filter_en = 1'b1;
  logic id_raw = 1'b0;
  logic force_host = 1'b0;
  logic force_dev = 1'b0;
  logic role_host, role_chg, busy;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int    cyc;
    bit    role;
    bit    chg;
    bit    busy;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t it;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  otg_role_filter #(.SETTLE_CYCLES(S)) u_otg_role_filter (
    .clk(clk), .rst(rst), .filter_en(filter_en), .id_raw(id_raw),
    .force_host(force_host), .force_dev(force_dev),
    .role_host(role_host), .role_chg(role_chg), .busy(busy)
  );

  task automatic expect_at(input int c, input bit r, input bit ch,
                           input bit b, input string tag);
    exp_t e;
    e.cyc = c; e.role = r; e.chg = ch; e.busy = b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: compare queued expectations in their cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      checks++;
      if (it.cyc != cyc || role_host !== it.role || role_chg !== it.chg ||
          busy !== it.busy) begin
        errors++;
        $display("FAIL %s cyc %0d: got role=%b chg=%b busy=%b, expected role=%b chg=%b busy=%b",
                 it.tag, cyc, role_host, role_chg, busy, it.role, it.chg, it.busy);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cyc %0d, expected finish", cyc);
      summary();
    end
  end

  initial begin
    int n;
    int m;
    // R1 / R2: host level held through reset
    repeat (3) @(negedge clk);
    n = cyc; rst = 1'b0;
    expect_at(n+1,   0, 0, 0, "R1 reset state");
    expect_at(n+2,   0, 0, 1, "R7 busy on host level");
    expect_at(n+1+S, 0, 0, 1, "R2 not yet switched");
    expect_at(n+2+S, 1, 1, 0, "R2 switch to host / R8 pulse");
    expect_at(n+3+S, 1, 0, 0, "R8 pulse one cycle");
    wait_cyc(n+6+S);

    // R3: short glitch to device level
    n = cyc; id_raw = 1'b1;
    expect_at(n+2, 1, 0, 1, "R7 busy during glitch");
    wait_cyc(n+5);
    m = cyc; id_raw = 1'b0;
    expect_at(m+2,   1, 0, 0, "R3 busy drops after glitch");
    expect_at(n+2+S, 1, 0, 0, "R3 glitch ignored");
    wait_cyc(n+6+S);

    // R5: force device
    n = cyc; force_dev = 1'b1;
    expect_at(n+1,   1, 0, 1, "R5 busy after force_dev");
    expect_at(n+S,   1, 0, 1, "R5 not yet forced");
    expect_at(n+1+S, 0, 1, 0, "R5 forced device");
    wait_cyc(n+4+S);

    // R4: force_host beats force_dev
    n = cyc; force_host = 1'b1;
    expect_at(n+S,   0, 0, 1, "R4 still device");
    expect_at(n+1+S, 1, 1, 0, "R4 host priority");
    wait_cyc(n+4+S);

    // R6: release with same requested role: no change
    n = cyc; force_host = 1'b0; force_dev = 1'b0;
    expect_at(n+1,   1, 0, 0, "R6 release same role idle");
    expect_at(n+2+S, 1, 0, 0, "R6 release no change");
    wait_cyc(n+4+S);

    // R2: pin to device level
    n = cyc; id_raw = 1'b1;
    expect_at(n+1+S, 1, 0, 1, "R2 device pending");
    expect_at(n+2+S, 0, 1, 0, "R2 switch to device");
    wait_cyc(n+4+S);

    // R5: force applied then released before settling
    n = cyc; force_host = 1'b1;
    expect_at(n+1, 0, 0, 1, "R7 busy on force_host");
    wait_cyc(n+5);
    m = cyc; force_host = 1'b0;
    expect_at(m+1,   0, 0, 0, "R5 release cancels");
    expect_at(m+1+S, 0, 0, 0, "R5 no change after cancel");
    wait_cyc(m+4+S);

    // R6: force during a pin count restarts it
    n = cyc; id_raw = 1'b0;
    wait_cyc(n+8);
    m = cyc; force_host = 1'b1;
    expect_at(n+2+S, 0, 0, 1, "R6 count restarted");
    expect_at(m+S,   0, 0, 1, "R6 still pending");
    expect_at(m+1+S, 1, 1, 0, "R6 switch after restart");
    wait_cyc(m+4+S);
    force_host = 1'b0;
    wait_cyc(cyc+4);

    // R9: bypass mode
    rst = 1'b1; filter_en = 1'b0; id_raw = 1'b0;
    repeat (3) @(negedge clk);
    n = cyc; rst = 1'b0;
    expect_at(n+1, 0, 0, 0, "R1 reset state bypass");
    expect_at(n+2, 0, 0, 0, "R9 sync delay");
    expect_at(n+3, 1, 1, 0, "R9 host passes through");
    wait_cyc(n+6);
    m = cyc; id_raw = 1'b1;
    expect_at(m+2, 1, 0, 0, "R9 old role kept");
    expect_at(m+3, 0, 1, 0, "R9 device passes through");
    expect_at(m+4, 0, 0, 0, "R8 bypass pulse one cycle");
    wait_cyc(m+8);

    done = 1;
    summary();
  end
endmodule